// File: doc/BRIEF.md
# Paired-Word Instruction Fetch Unit

This block fetches program words for a processor pipeline over a pipelined Wishbone read master. Each bus cycle asks memory for two consecutive 32-bit instruction words and holds the two replies in a small two-slot buffer. The decode stage takes the buffered words one at a time through a valid/ready handshake, in program order, and each word comes with the byte address it was fetched from.

A new program counter can arrive at any time, for example when a branch is taken. The unit then lowers CYC on the next clock, throws away everything buffered or still on the way, and starts a fresh pair fetch at the new address. A bus error does not lose the word that failed. That word is handed to the decoder with an illegal flag, and fetching stops until the next program counter is supplied.

Top module: `pf2_dual_fetch`

## Requirements
- R1: While reset is high, `o_valid`, `o_wb_cyc` and `o_wb_stb` are low. The first bus cycle after reset starts at word address `RESET_PC >> 2`.
- R2: A bus cycle sends exactly two strobes, for word address A and then A+1. CYC stays high, through any number of wait states, until the second acknowledge, and drops on the clock after it. STB is never high while CYC is low.
- R3: While STB is high and STALL is asserted, the next clock keeps STB high and leaves `o_wb_adr` unchanged.
- R4: While `o_valid` is high and `i_ready` is low, the next clock keeps `o_valid`, `o_insn`, `o_pc` and `o_illegal` unchanged. A word is consumed on a clock where `o_valid` and `i_ready` are both high.
- R5: Words reach the decoder in fetch order. The second word of a pair carries the first word's `o_pc` plus 4 and becomes valid on the clock after the first word is consumed, provided it has already arrived. `o_insn` equals the data returned for that address.
- R6: No bus cycle starts while any buffered word is still unconsumed. After a completed pair, the next cycle starts at word address A+2.
- R7: One clock after `i_new_pc` is high, `o_wb_cyc` and `o_valid` are low and all buffered words are gone. The next bus cycle starts at word address `i_pc >> 2`, so the low two bits of `i_pc` are ignored. The first word delivered afterwards has `o_pc` equal to `i_pc` with its low two bits cleared.
- R8: An acknowledge that arrives on the same clock as `i_new_pc` is not stored and is never presented.
- R9: A word answered with ERR instead of ACK is presented with `o_illegal` high (normal words have `o_illegal` low), at its own address. No further bus cycle starts until `i_new_pc` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| i_new_pc | input | 1 | Load a new program counter and abort any fetch |
| i_pc | input | ADDR_W | New program counter (byte address) |
| i_ready | input | 1 | Decoder accepts the presented word |
| o_valid | output | 1 | A fetched word is presented |
| o_insn | output | DATA_W | Presented instruction word |
| o_pc | output | ADDR_W | Byte address of the presented word |
| o_illegal | output | 1 | Presented word came back with a bus error |
| o_wb_cyc | output | 1 | Wishbone cycle |
| o_wb_stb | output | 1 | Wishbone strobe |
| o_wb_adr | output | ADDR_W-2 | Wishbone word address |
| i_wb_stall | input | 1 | Wishbone stall |
| i_wb_ack | input | 1 | Wishbone acknowledge |
| i_wb_err | input | 1 | Wishbone error |
| i_wb_data | input | DATA_W | Wishbone read data |

## Verification
The assertions assume a well-behaved slave. It acknowledges only requests it has already taken, one reply per request and in order, it never raises ACK and ERR together, and it forgets all pending replies once CYC falls. The bench memory model queues every accepted strobe with a random latency, answers only from that queue while CYC is high, and clears the queue when CYC is low. The bench also never raises `i_ready` on a clock where it asserts `i_new_pc`, so a word is never consumed on the same clock it is flushed.

// File: rtl/pf2_pkg.sv
package pf2_pkg;
   // number of instruction words requested per bus cycle
   localparam int unsigned PAIR_WORDS = 2;
   localparam int unsigned SLOT_IW    = $clog2(PAIR_WORDS);

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,   // waiting for the buffer to drain
      FS_BUS  = 2'd1,   // bus cycle in progress
      FS_HALT = 2'd2    // stopped after a bus error
   } fetch_state_e;
endpackage

// File: rtl/pf2_bus_master.sv
module pf2_bus_master
   import pf2_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                flush,
   input  logic [ADDR_W-3:0]   flush_word,
   input  logic                buf_busy,
   output logic                wb_cyc,
   output logic                wb_stb,
   output logic [ADDR_W-3:0]   wb_adr,
   input  logic                wb_stall,
   input  logic                wb_ack,
   input  logic                wb_err,
   input  logic [DATA_W-1:0]   wb_dat,
   output logic                wr_en,
   output logic [SLOT_IW-1:0]  wr_idx,
   output logic [ADDR_W-3:0]   wr_word,
   output logic [DATA_W-1:0]   wr_dat,
   output logic                wr_bad
);
   localparam int unsigned AW = ADDR_W - 2;

   if (PAIR_WORDS != 2) begin : g_bad_pair
      $error("pf2_bus_master: strobe sequencing is built for two words");
   end

   fetch_state_e        state_q;
   logic [AW-1:0]       base_q;
   logic                sent_q;
   logic [SLOT_IW-1:0]  rcvd_q;
   logic                resp;

   assign resp = wb_ack | wb_err;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= FS_IDLE;
         base_q  <= RESET_PC[ADDR_W-1:2];
         wb_cyc  <= 1'b0;
         wb_stb  <= 1'b0;
         wb_adr  <= '0;
         sent_q  <= 1'b0;
         rcvd_q  <= '0;
      end else if (flush) begin
         state_q <= FS_IDLE;
         base_q  <= flush_word;
         wb_cyc  <= 1'b0;
         wb_stb  <= 1'b0;
         sent_q  <= 1'b0;
         rcvd_q  <= '0;
      end else begin
         case (state_q)
            FS_IDLE: begin
               if (!buf_busy) begin
                  wb_cyc  <= 1'b1;
                  wb_stb  <= 1'b1;
                  wb_adr  <= base_q;
                  sent_q  <= 1'b0;
                  rcvd_q  <= '0;
                  state_q <= FS_BUS;
               end
            end
            FS_BUS: begin
               if (wb_stb && !wb_stall) begin
                  if (sent_q) begin
                     wb_stb <= 1'b0;
                  end else begin
                     sent_q <= 1'b1;
                     wb_adr <= wb_adr + AW'(1);
                  end
               end
               if (resp) begin
                  rcvd_q <= rcvd_q + SLOT_IW'(1);
                  if (wb_err) begin
                     wb_cyc  <= 1'b0;
                     wb_stb  <= 1'b0;
                     state_q <= FS_HALT;
                  end else if (rcvd_q == SLOT_IW'(PAIR_WORDS - 1)) begin
                     wb_cyc  <= 1'b0;
                     wb_stb  <= 1'b0;
                     base_q  <= base_q + AW'(PAIR_WORDS);
                     state_q <= FS_IDLE;
                  end
               end
            end
            default: begin
               state_q <= FS_HALT;
            end
         endcase
      end
   end

   // replies are written only while our own cycle is live and not being aborted
   assign wr_en   = (state_q == FS_BUS) && resp && !flush;
   assign wr_idx  = rcvd_q;
   assign wr_word = base_q + AW'(rcvd_q);
   assign wr_dat  = wb_dat;
   assign wr_bad  = wb_err;

   assert_stb_in_cyc_R2: assert property (@(posedge clk) disable iff (rst)
      wb_stb |-> wb_cyc);

   assert_two_strobes_R2: assert property (@(posedge clk) disable iff (rst)
      (wb_stb && !wb_stall && sent_q && !flush) |=> !wb_stb);

   assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (wb_stb && wb_stall && !flush && !wb_err) |=> (wb_stb && $stable(wb_adr)));

   assert_no_fetch_while_full_R6: assert property (@(posedge clk) disable iff (rst)
      (state_q == FS_IDLE && buf_busy && !flush) |=> !wb_cyc);

   assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
      flush |=> !wb_cyc);

   assert_halt_after_err_R9: assert property (@(posedge clk) disable iff (rst)
      (state_q == FS_HALT && !flush) |=> !wb_cyc);
endmodule

// File: rtl/pf2_slot_buf.sv
module pf2_slot_buf
   import pf2_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                flush,
   input  logic                wr_en,
   input  logic [SLOT_IW-1:0]  wr_idx,
   input  logic [ADDR_W-3:0]   wr_word,
   input  logic [DATA_W-1:0]   wr_dat,
   input  logic                wr_bad,
   input  logic                out_ready,
   output logic                out_valid,
   output logic [DATA_W-1:0]   out_insn,
   output logic [ADDR_W-1:0]   out_pc,
   output logic                out_bad,
   output logic                busy
);
   localparam int unsigned AW = ADDR_W - 2;

   logic [PAIR_WORDS-1:0] vld;
   logic [PAIR_WORDS-1:0] bad_a;
   logic [DATA_W-1:0]     dat_a  [PAIR_WORDS];
   logic [AW-1:0]         word_a [PAIR_WORDS];
   logic [SLOT_IW-1:0]    rd_q;
   logic                  take;

   assign take = out_valid && out_ready;

   for (genvar i = 0; i < PAIR_WORDS; i++) begin : g_slot
      logic              v_q;
      logic              b_q;
      logic [DATA_W-1:0] d_q;
      logic [AW-1:0]     w_q;

      always_ff @(posedge clk) begin
         if (rst || flush) begin
            v_q <= 1'b0;
         end else if (wr_en && wr_idx == SLOT_IW'(i)) begin
            v_q <= 1'b1;
            d_q <= wr_dat;
            w_q <= wr_word;
            b_q <= wr_bad;
         end else if (take && rd_q == SLOT_IW'(i)) begin
            v_q <= 1'b0;
         end
      end

      assign vld[i]    = v_q;
      assign bad_a[i]  = b_q;
      assign dat_a[i]  = d_q;
      assign word_a[i] = w_q;
   end

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         rd_q <= '0;
      end else if (take) begin
         rd_q <= rd_q + SLOT_IW'(1);
      end
   end

   assign out_valid = vld[rd_q];
   assign out_insn  = dat_a[rd_q];
   assign out_pc    = {word_a[rd_q], 2'b00};
   assign out_bad   = bad_a[rd_q];
   assign busy      = |vld;

   assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready && !flush) |=>
      (out_valid && $stable(out_insn) && $stable(out_pc) && $stable(out_bad)));

   assert_next_pc_R5: assert property (@(posedge clk) disable iff (rst)
      (take && rd_q == '0 && vld[1] && !flush) |=>
      (out_valid && out_pc == $past(out_pc) + ADDR_W'(4)));

   assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> !vld[wr_idx]);

   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
      flush |=> !busy);
endmodule

// File: rtl/pf2_dual_fetch.sv
module pf2_dual_fetch
   import pf2_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter logic [ADDR_W-1:0] RESET_PC = 'h100
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              i_new_pc,
   input  logic [ADDR_W-1:0] i_pc,
   input  logic              i_ready,
   output logic              o_valid,
   output logic [DATA_W-1:0] o_insn,
   output logic [ADDR_W-1:0] o_pc,
   output logic              o_illegal,
   output logic              o_wb_cyc,
   output logic              o_wb_stb,
   output logic [ADDR_W-3:0] o_wb_adr,
   input  logic              i_wb_stall,
   input  logic              i_wb_ack,
   input  logic              i_wb_err,
   input  logic [DATA_W-1:0] i_wb_data
);
   if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_aw
      $error("pf2_dual_fetch: ADDR_W must lie in 4..64");
   end
   if (DATA_W < 8) begin : g_bad_dw
      $error("pf2_dual_fetch: DATA_W must be at least 8");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_rpc
      $error("pf2_dual_fetch: RESET_PC must be word aligned");
   end

   logic                buf_busy;
   logic                wr_en;
   logic [SLOT_IW-1:0]  wr_idx;
   logic [ADDR_W-3:0]   wr_word;
   logic [DATA_W-1:0]   wr_dat;
   logic                wr_bad;
   logic                unused_pc_lo;

   assign unused_pc_lo = ^i_pc[1:0];

   pf2_bus_master #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .RESET_PC (RESET_PC)
   ) u_bus (
      .clk        (clk),
      .rst        (rst),
      .flush      (i_new_pc),
      .flush_word (i_pc[ADDR_W-1:2]),
      .buf_busy   (buf_busy),
      .wb_cyc     (o_wb_cyc),
      .wb_stb     (o_wb_stb),
      .wb_adr     (o_wb_adr),
      .wb_stall   (i_wb_stall),
      .wb_ack     (i_wb_ack),
      .wb_err     (i_wb_err),
      .wb_dat     (i_wb_data),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_word    (wr_word),
      .wr_dat     (wr_dat),
      .wr_bad     (wr_bad)
   );

   pf2_slot_buf #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_buf (
      .clk       (clk),
      .rst       (rst),
      .flush     (i_new_pc),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_word   (wr_word),
      .wr_dat    (wr_dat),
      .wr_bad    (wr_bad),
      .out_ready (i_ready),
      .out_valid (o_valid),
      .out_insn  (o_insn),
      .out_pc    (o_pc),
      .out_bad   (o_illegal),
      .busy      (buf_busy)
   );

   assert_reset_quiet_R1: assert property (@(posedge clk)
      $past(rst) |-> (!o_valid && !o_wb_cyc && !o_wb_stb));

   assert_flush_clears_R7: assert property (@(posedge clk) disable iff (rst)
      i_new_pc |=> (!o_valid && !o_wb_cyc));
endmodule

// File: tb/pf2_dual_fetch_tb_top.sv
module pf2_dual_fetch_tb_top;
   localparam logic [31:0] RST_PC = 32'h0000_0100;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        new_pc = 1'b0;
   logic [31:0] pc_in = '0;
   logic        ready = 1'b0;
   logic        valid;
   logic [31:0] insn;
   logic [31:0] opc;
   logic        illegal;
   logic        cyc, stb;
   logic [29:0] adr;
   logic        stall = 1'b0, ack = 1'b0, err = 1'b0;
   logic [31:0] dat = '0;

   always #5 clk = ~clk;

   pf2_dual_fetch #(.ADDR_W(32), .DATA_W(32), .RESET_PC(RST_PC)) dut_i (
      .clk(clk), .rst(rst), .i_new_pc(new_pc), .i_pc(pc_in), .i_ready(ready),
      .o_valid(valid), .o_insn(insn), .o_pc(opc), .o_illegal(illegal),
      .o_wb_cyc(cyc), .o_wb_stb(stb), .o_wb_adr(adr),
      .i_wb_stall(stall), .i_wb_ack(ack), .i_wb_err(err), .i_wb_data(dat));

   int checks = 0, fails = 0, cyc_n = 0, idle_cnt = 0;
   bit wd_hit = 0;
   int p_stall = 0, p_ready = 100, p_lat = 0, p_newpc = 0;
   bit err_armed = 0;
   logic [29:0] err_word = '0;
   bit req_np = 0, np_on_ack = 0;
   logic [31:0] req_pc = '0;
   logic [29:0] q_adr [4];
   int q_due [4];
   int q_n = 0, buffered = 0, n_stb = 0, n_ack = 0;
   logic [31:0] exp_pc;
   logic [29:0] bus_next, first_adr;
   bit prev_cyc = 0, tainted = 0, halted = 0, halt_bad = 0, saw_illegal = 0;
   bit hold_pend = 0, stall_pend = 0, chk_np = 0, r8_pend = 0, r1_pend = 0, r8_done = 0;
   logic [31:0] h_insn, h_pc, r8_pc;
   logic [29:0] s_adr;

   function automatic logic [31:0] memf(input logic [29:0] w);
      return {w[14:0], ~w[16:0]} ^ 32'hA5C3_0F1E;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      bit np, a, e, s, r;
      logic [31:0] tgt;
      @(negedge clk);
      cyc_n++;
      idle_cnt++;
      if (idle_cnt > 2000 && !wd_hit) begin
         wd_hit = 1;
         chk(0, "WATCHDOG", "no progress", idle_cnt, 0);
      end
      if (chk_np) begin
         chk(!cyc && !valid, "R7", "cyc/valid after new pc", {cyc, valid}, 0);
         chk_np = 0;
      end
      if (hold_pend) begin
         chk(valid && insn == h_insn && opc == h_pc, "R4", "held word", opc, h_pc);
         hold_pend = 0;
      end
      if (stall_pend) begin
         chk(stb && adr == s_adr, "R3", "address under stall", {2'b0, adr}, {2'b0, s_adr});
         stall_pend = 0;
      end
      if (cyc && !prev_cyc) begin
         chk(buffered == 0, "R6", "buffered words at cycle start", buffered, 0);
         if (halted) halt_bad = 1;
         n_stb = 0; n_ack = 0; tainted = 0;
      end
      if (!cyc && prev_cyc && !tainted) begin
         chk(n_stb == 2 && n_ack == 2, "R2", "strobes/acks per cycle", n_stb * 16 + n_ack, 32'h22);
         bus_next = bus_next + 30'd2;
      end
      prev_cyc = cyc;
      if (!cyc) q_n = 0;

      np = req_np;
      req_np = 0;
      if (!np && p_newpc > 0 && ($urandom % 1000) < p_newpc) np = 1;
      a = 0; e = 0; dat = '0;
      if (cyc && q_n > 0 && q_due[0] <= cyc_n) begin
         if (err_armed && q_adr[0] == err_word) e = 1; else a = 1;
         dat = e ? 32'h0 : memf(q_adr[0]);
         for (int k = 0; k < 3; k++) begin
            q_adr[k] = q_adr[k+1];
            q_due[k] = q_due[k+1];
         end
         q_n--;
      end
      tgt = np ? (req_pc != 0 ? req_pc : ($urandom & 32'h0000_FFFF)) : 32'h0;
      if (np_on_ack && a) begin
         np = 1; np_on_ack = 0;
         tgt = $urandom & 32'h0000_FFFF;
         r8_pend = 1; r8_pc = tgt & ~32'h3;
      end
      s = ($urandom % 100) < p_stall;
      if (cyc && stb && !s) begin
         if (n_stb == 0) begin
            chk(adr == bus_next, "R6", "pair start address", {2'b0, adr}, {2'b0, bus_next});
            if (r1_pend) begin
               chk(adr == RST_PC[31:2], "R1", "first address after reset", {2'b0, adr}, RST_PC >> 2);
               r1_pend = 0;
            end
            first_adr = adr;
         end else begin
            chk(adr == first_adr + 30'd1, "R2", "second strobe address", {2'b0, adr}, {2'b0, first_adr + 30'd1});
         end
         n_stb++;
         q_adr[q_n] = adr;
         q_due[q_n] = cyc_n + 1 + ($urandom % (p_lat + 1));
         q_n++;
      end
      stall_pend = stb && s && !np && !e;
      s_adr = adr;
      r = (($urandom % 100) < p_ready) && !np;
      if (valid && r) begin
         bit exp_bad;
         exp_bad = err_armed && (exp_pc[31:2] == err_word);
         chk(opc == exp_pc, "R5", "word order pc", opc, exp_pc);
         chk(illegal == exp_bad, exp_bad ? "R9" : "R5", "illegal flag", illegal, exp_bad);
         if (!exp_bad) chk(insn == memf(exp_pc[31:2]), "R5", "word data", insn, memf(exp_pc[31:2]));
         else saw_illegal = 1;
         if (r8_pend) begin
            chk(opc == r8_pc, "R8", "first word after ack-with-new-pc", opc, r8_pc);
            r8_pend = 0; r8_done = 1;
         end
         exp_pc = exp_pc + 32'd4;
         buffered--;
         idle_cnt = 0;
      end
      hold_pend = valid && !r && !np;
      h_insn = insn; h_pc = opc;
      if (cyc && (a || e) && !np) begin
         buffered++;
         n_ack++;
         if (e) begin halted = 1; tainted = 1; end
      end
      if (np) begin
         if (halted) begin
            chk(!halt_bad && saw_illegal, "R9", "halt until new pc", halt_bad, 0);
            halted = 0; halt_bad = 0; err_armed = 0;
         end
         buffered = 0;
         exp_pc = tgt & ~32'h3;
         bus_next = tgt[31:2];
         tainted = 1;
         chk_np = 1;
         hold_pend = 0; stall_pend = 0;
         idle_cnt = 0;
      end
      new_pc = np; pc_in = tgt; ack = a; err = e; stall = s; ready = r;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      exp_pc = RST_PC;
      bus_next = RST_PC[31:2];
      repeat (4) @(negedge clk);
      chk(!valid && !cyc && !stb, "R1", "outputs in reset", {valid, cyc, stb}, 0);
      rst = 1'b0;
      r1_pend = 1;
      // directed: full speed, no waits
      p_stall = 0; p_ready = 100; p_lat = 0;
      for (int i = 0; i < 80 && !wd_hit; i++) step();
      // slow memory, stalls and a hesitant decoder
      p_stall = 50; p_ready = 40; p_lat = 4;
      for (int i = 0; i < 500 && !wd_hit; i++) step();
      // directed: new pc on the same clock as an acknowledge (R8)
      p_ready = 100;
      np_on_ack = 1;
      for (int i = 0; i < 300 && !wd_hit && !r8_done; i++) step();
      chk(r8_done, "R8", "ack-with-new-pc case reached", r8_done, 1);
      for (int i = 0; i < 40 && !wd_hit; i++) step();
      // directed: bus error on the second word of a pair (R9)
      p_stall = 20; p_lat = 2;
      err_armed = 1; err_word = bus_next + 30'd1;
      for (int i = 0; i < 400 && !wd_hit && !(halted && saw_illegal && buffered == 0); i++) step();
      for (int i = 0; i < 40 && !wd_hit; i++) step();
      chk(!cyc, "R9", "bus idle while halted", cyc, 0);
      req_np = 1; req_pc = 32'h0000_2002;
      step();
      req_pc = 32'h0;
      // random mix with spontaneous redirects
      p_stall = 30; p_ready = 60; p_lat = 3; p_newpc = 15;
      for (int i = 0; i < 4000 && !wd_hit; i++) step();
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule